// File: doc/BRIEF.md
# Profile-Driven Linear Sweep Generator

This block produces a 32-bit sweep word that a synthesizer core can use as a frequency, phase or amplitude setting. The word moves linearly between a lower start limit and an upper end limit. One external profile input picks the direction from its synchronised level. A high level climbs toward the end limit and a low level descends toward the start limit. Each direction has its own step size and its own step interval. An 8-bit loadable down counter paces the steps.

In dwell operation, the word parks at whichever limit it reaches and stays there until the direction changes. In no-dwell operation only the climb is used. On reaching the end limit, the word jumps back to the start limit and waits there for the next rising edge on the profile input. An update strobe, when enabled by a control bit, restarts the step interval in the middle of a ramp. The start limit must not exceed the end limit.

Top module: `lin_sweep_gen`

## Requirements
- R1: While `rstN` is low, or while `sweepEn` is low, `sweepWord` equals `startLimit` and the step timer holds 0. On the first cycle after `sweepEn` goes high, the word is loaded with `startLimit`. No step is taken on that cycle.
- R2: `profilePin` passes through two flip-flops before use. A change on the pin is acted on at the third rising clock edge after it is applied.
- R3: A rising or falling edge of the synchronised profile loads the timer with the rate of the new direction (`riseRate` when high, `fallRate` when low). No step is taken in that cycle.
- R4: When the timer holds 0 or 1 and no load is requested, one step is taken and the timer is reloaded with the current direction's rate. A rate R of 2 or more therefore gives one step every R cycles. A rate of 0 or 1 gives one step on every cycle.
- R5: In dwell mode (`noDwell`=0) with the profile high, each step adds `riseDelta`. A step that would reach or pass `endLimit` sets the word to `endLimit`, which is then held.
- R6: In dwell mode with the profile low, each step subtracts `fallDelta`. A step that would reach or pass `startLimit` sets the word to `startLimit`, which is then held.
- R7: In no-dwell mode, a rising step that would reach or pass `endLimit` loads `startLimit` instead. The word then stays there until the next rising edge of the synchronised profile, even if the profile remains high.
- R8: In no-dwell mode, no downward step is taken. While the profile is low, the word stays unchanged, and `fallDelta` and `fallRate` have no effect on it.
- R9: With `sweepEn`, `timerReload` and `ioUpdate` all high, the timer reloads with the current direction's rate. This reload takes priority over a timer expiry in the same cycle, so no step occurs. When `timerReload` is low, `ioUpdate` has no effect.
- R10: A change of direction in the middle of a ramp continues stepping from the present word, with no jump.
- R11: The direction of every step follows the live synchronised profile level: high means up, low means down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| profilePin | input | 1 | Direction input, asynchronous |
| ioUpdate | input | 1 | Update strobe, one cycle |
| sweepEn | input | 1 | Enables sweeping |
| noDwell | input | 1 | Selects no-dwell operation |
| timerReload | input | 1 | Lets `ioUpdate` reload the timer |
| startLimit | input | 32 | Lower limit and start point |
| endLimit | input | 32 | Upper limit |
| riseDelta | input | 32 | Step size while climbing |
| fallDelta | input | 32 | Step size while descending |
| riseRate | input | 8 | Step interval while climbing |
| fallRate | input | 8 | Step interval while descending |
| sweepWord | output | 32 | Current sweep word |

## Verification
A timer expiry can land in the same cycle as a timer load, whether the load comes from a profile edge or from an enabled update strobe. In that cycle the load must win and the step must be dropped. The bench provokes this by pulsing the update strobe with reload enabled on every cycle of a running ramp, so every expiry collides with a reload. It also flips the profile in the middle of ramps. A behavioural reference model predicts every cycle, and any step that slips through shows up as a word change that the model does not expect.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef struct packed {
    logic stepUp;     // add the rising delta this cycle
    logic stepDown;   // subtract the falling delta this cycle
    logic clearPark;  // rising profile edge: release a no-dwell park
  } sweepStrb_t;
endpackage

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
#(
  parameter int RATE_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              profilePin,
  input  logic              ioUpdate,
  input  logic              sweepEn,
  input  logic              noDwell,
  input  logic              timerReload,
  input  logic [RATE_W-1:0] riseRate,
  input  logic [RATE_W-1:0] fallRate,
  output sweepStrb_t        strb,
  output logic [RATE_W-1:0] timerCnt
);
  localparam logic [RATE_W-1:0] ONE = RATE_W'(1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic profLvl, profPrev;
  logic riseEdge, fallEdge, loadReq, expire;
  logic [RATE_W-1:0] rateSel;

  assign profLvl  = syncQ[SYNC_STAGES-1];
  assign riseEdge = profLvl & ~profPrev;
  assign fallEdge = ~profLvl & profPrev;
  assign rateSel  = profLvl ? riseRate : fallRate;
  assign loadReq  = sweepEn & (riseEdge | fallEdge | (ioUpdate & timerReload));
  assign expire   = sweepEn & ~loadReq & (timerCnt <= ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      profPrev <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], profilePin};
      profPrev <= profLvl;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 timerCnt <= '0;
    else if (!sweepEn)         timerCnt <= '0;
    else if (loadReq | expire) timerCnt <= rateSel;
    else                       timerCnt <= timerCnt - ONE;
  end

  always_comb begin
    strb.stepUp    = expire & profLvl;
    strb.stepDown  = expire & ~profLvl & ~noDwell;
    strb.clearPark = riseEdge;
  end
endmodule

// File: rtl/sweep_dpath.sv
module sweep_dpath
  import sweep_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sweepEn,
  input  logic              noDwell,
  input  sweepStrb_t        strb,
  input  logic [WORD_W-1:0] startLimit,
  input  logic [WORD_W-1:0] endLimit,
  input  logic [WORD_W-1:0] riseDelta,
  input  logic [WORD_W-1:0] fallDelta,
  output logic [WORD_W-1:0] sweepWord,
  output logic              running,
  output logic              parked
);
  logic [WORD_W-1:0] acc;
  logic [WORD_W:0]   upSum;
  logic [WORD_W-1:0] aboveStart;
  logic              hitEnd, hitStart;

  assign upSum      = {1'b0, acc} + {1'b0, riseDelta};
  assign aboveStart = acc - startLimit;
  assign hitEnd     = upSum >= {1'b0, endLimit};
  assign hitStart   = (acc <= startLimit) || (aboveStart <= fallDelta);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc     <= '0;
      parked  <= 1'b0;
      running <= 1'b0;
    end else begin
      running <= sweepEn;
      if (!sweepEn || !running) begin
        acc    <= startLimit;
        parked <= 1'b0;
      end else begin
        if (strb.clearPark) parked <= 1'b0;
        if (strb.stepUp && !parked) begin
          if (hitEnd) begin
            if (noDwell) begin
              acc    <= startLimit;
              parked <= 1'b1;
            end else begin
              acc <= endLimit;
            end
          end else begin
            acc <= upSum[WORD_W-1:0];
          end
        end else if (strb.stepDown) begin
          acc <= hitStart ? startLimit : acc - fallDelta;
        end
      end
    end
  end

  assign sweepWord = (running && sweepEn) ? acc : startLimit;
endmodule

// File: rtl/lin_sweep_gen.sv
module lin_sweep_gen
  import sweep_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int RATE_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              profilePin,
  input  logic              ioUpdate,
  input  logic              sweepEn,
  input  logic              noDwell,
  input  logic              timerReload,
  input  logic [WORD_W-1:0] startLimit,
  input  logic [WORD_W-1:0] endLimit,
  input  logic [WORD_W-1:0] riseDelta,
  input  logic [WORD_W-1:0] fallDelta,
  input  logic [RATE_W-1:0] riseRate,
  input  logic [RATE_W-1:0] fallRate,
  output logic [WORD_W-1:0] sweepWord
);
  sweepStrb_t        strb;
  logic [RATE_W-1:0] timerCnt;
  logic              running, parked;

  sweep_ctrl #(.RATE_W(RATE_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .profilePin(profilePin), .ioUpdate(ioUpdate),
    .sweepEn(sweepEn), .noDwell(noDwell), .timerReload(timerReload),
    .riseRate(riseRate), .fallRate(fallRate), .strb(strb), .timerCnt(timerCnt)
  );

  sweep_dpath #(.WORD_W(WORD_W)) u_dpath (
    .clk(clk), .rstN(rstN), .sweepEn(sweepEn), .noDwell(noDwell), .strb(strb),
    .startLimit(startLimit), .endLimit(endLimit), .riseDelta(riseDelta),
    .fallDelta(fallDelta), .sweepWord(sweepWord), .running(running), .parked(parked)
  );
endmodule

// File: rtl/lin_sweep_chk.sv
module lin_sweep_chk
  import sweep_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int RATE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sweepEn,
  input logic              noDwell,
  input logic              ioUpdate,
  input logic              timerReload,
  input logic [WORD_W-1:0] startLimit,
  input logic [WORD_W-1:0] endLimit,
  input logic [WORD_W-1:0] riseDelta,
  input logic [WORD_W-1:0] sweepWord,
  input sweepStrb_t        strb,
  input logic [RATE_W-1:0] timerCnt,
  input logic              running,
  input logic              parked
);
  // R1: a disabled cycle leaves the start limit on the output and an idle timer
  a_r1_disabled_start: assert property (@(posedge clk) disable iff (!rstN)
    !sweepEn |=> (sweepWord == startLimit) && (timerCnt == '0));

  // R5: a dwell climb step either adds the delta exactly or lands on the end limit
  a_r5_no_overshoot: assert property (@(posedge clk) disable iff (!rstN)
    (sweepEn && running && strb.stepUp && !parked && !noDwell) |=>
      (!sweepEn || sweepWord == $past(endLimit) ||
       sweepWord == $past(sweepWord) + $past(riseDelta)));

  // R7: a no-dwell climb that reaches the end limit falls back to the start limit
  a_r7_snap_back: assert property (@(posedge clk) disable iff (!rstN)
    (sweepEn && running && noDwell && strb.stepUp && !parked &&
     ({1'b0, sweepWord} + {1'b0, riseDelta} >= {1'b0, endLimit})) |=>
      (!sweepEn || sweepWord == $past(startLimit)));

  // R8: no downward step is issued in no-dwell mode
  a_r8_no_fall_step: assert property (@(posedge clk) disable iff (!rstN)
    noDwell |-> !strb.stepDown);

  // R9: an enabled update strobe suppresses any step in its cycle
  a_r9_reload_priority: assert property (@(posedge clk) disable iff (!rstN)
    (sweepEn && ioUpdate && timerReload) |-> !(strb.stepUp || strb.stepDown));
endmodule

bind lin_sweep_gen lin_sweep_chk #(.WORD_W(WORD_W), .RATE_W(RATE_W)) u_chk (
  .clk(clk), .rstN(rstN), .sweepEn(sweepEn), .noDwell(noDwell),
  .ioUpdate(ioUpdate), .timerReload(timerReload), .startLimit(startLimit),
  .endLimit(endLimit), .riseDelta(riseDelta), .sweepWord(sweepWord),
  .strb(strb), .timerCnt(timerCnt), .running(running), .parked(parked)
);

// File: tb/lin_sweep_gen_bench.sv
module lin_sweep_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        profilePin = 1'b0, ioUpdate = 1'b0, sweepEn = 1'b0;
  logic        noDwell = 1'b0, timerReload = 1'b0;
  logic [31:0] startLimit = 32'd1000, endLimit = 32'd1100;
  logic [31:0] riseDelta = 32'd7, fallDelta = 32'd13;
  logic [7:0]  riseRate = 8'd3, fallRate = 8'd0;
  logic [31:0] sweepWord;

  lin_sweep_gen u_lin_sweep_gen (
    .clk(clk), .rstN(rstN), .profilePin(profilePin), .ioUpdate(ioUpdate),
    .sweepEn(sweepEn), .noDwell(noDwell), .timerReload(timerReload),
    .startLimit(startLimit), .endLimit(endLimit), .riseDelta(riseDelta),
    .fallDelta(fallDelta), .riseRate(riseRate), .fallRate(fallRate),
    .sweepWord(sweepWord)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 0;
  string tag = "R1";

  // Behavioural reference state
  bit mPin1, mPin2, mPrev, mRun, mPark;
  int mTimer;
  longint mAcc;

  always @(posedge clk) begin
    if (!rstN) begin
      mPin1 = 0; mPin2 = 0; mPrev = 0; mRun = 0; mPark = 0; mTimer = 0; mAcc = 0;
    end else begin
      bit up, rise, fall, load, fire;
      int rate;
      up   = mPin2;
      rise = mPin2 && !mPrev;
      fall = !mPin2 && mPrev;
      load = sweepEn && (rise || fall || (ioUpdate && timerReload));
      fire = sweepEn && !load && (mTimer <= 1);
      rate = up ? int'(riseRate) : int'(fallRate);
      if (!sweepEn) mTimer = 0;
      else if (load || fire) mTimer = rate;
      else mTimer = mTimer - 1;
      if (!sweepEn || !mRun) begin
        mAcc = startLimit; mPark = 0;
      end else begin
        if (rise) mPark = 0;
        if (fire && up && !mPark) begin
          if (mAcc + longint'(riseDelta) >= longint'(endLimit)) begin
            if (noDwell) begin mAcc = startLimit; mPark = 1; end
            else mAcc = endLimit;
          end else mAcc = mAcc + longint'(riseDelta);
        end else if (fire && !up && !noDwell) begin
          if (mAcc - longint'(fallDelta) <= longint'(startLimit)) mAcc = startLimit;
          else mAcc = mAcc - longint'(fallDelta);
        end
      end
      mRun = sweepEn;
      mPrev = mPin2; mPin2 = mPin1; mPin1 = profilePin;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: sweepWord=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      check(tag, sweepWord, (mRun && sweepEn) ? 32'(mAcc) : startLimit);
    end
  endtask

  logic [31:0] held;

  initial begin
    // R1: reset state
    cyc(3);
    check("R1", sweepWord, 32'd1000);
    rstN = 1'b1;
    cyc(2);
    // R6/R11: enabled with profile low, steps downward and clamps at start
    tag = "R6"; sweepEn = 1'b1;
    cyc(10);
    check("R6", sweepWord, 32'd1000);
    // R2/R3/R4/R5: climb with rate 3 up to the end limit, then hold
    tag = "R5"; profilePin = 1'b1;
    cyc(80);
    check("R5", sweepWord, 32'd1100);
    // R6: descend with rate 0, one step per clock, clamp at start
    tag = "R6"; profilePin = 1'b0;
    cyc(20);
    check("R6", sweepWord, 32'd1000);
    // R10: reversal in the middle of a ramp
    tag = "R10"; profilePin = 1'b1; cyc(15);
    profilePin = 1'b0; cyc(3);
    profilePin = 1'b1; cyc(20);
    // R7: no-dwell climb snaps back and parks while profile stays high
    tag = "R7"; profilePin = 1'b0; cyc(20);
    noDwell = 1'b1; profilePin = 1'b1;
    cyc(70);
    check("R7", sweepWord, 32'd1000);
    // R8: falling words unused in no-dwell mode
    tag = "R8"; profilePin = 1'b0; fallRate = 8'd1; cyc(12);
    check("R8", sweepWord, 32'd1000);
    tag = "R7"; profilePin = 1'b1; cyc(20);
    tag = "R8"; profilePin = 1'b0; cyc(10);
    // R9: update strobe with reload on every cycle blocks stepping
    tag = "R9"; noDwell = 1'b0; profilePin = 1'b1; cyc(5);
    held = sweepWord;
    ioUpdate = 1'b1; timerReload = 1'b1;
    cyc(20);
    check("R9", sweepWord, held);
    // R9: update strobe without reload enable is ignored
    timerReload = 1'b0; cyc(20);
    ioUpdate = 1'b0; cyc(5);
    // R4: fast rates 0 and 1 on the climb
    tag = "R4"; profilePin = 1'b0; fallRate = 8'd0; cyc(15);
    riseRate = 8'd0; profilePin = 1'b1; cyc(20);
    profilePin = 1'b0; cyc(15);
    riseRate = 8'd1; profilePin = 1'b1; cyc(10);
    // R1: disable in the middle of a sweep returns to start at once
    tag = "R1"; riseRate = 8'd4; profilePin = 1'b0; cyc(15);
    profilePin = 1'b1; cyc(12);
    sweepEn = 1'b0; #1;
    check("R1", sweepWord, 32'd1000);
    cyc(4);
    sweepEn = 1'b1; cyc(30);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule